// File: doc/BRIEF.md
# Bussed Fault Group Controller

This block coordinates fault handling for a group of regulator channels that share one active-low, wired-AND fault line. A channel enabled as a fault source pulls the line low when its own fault detector raises a request. Any channel enabled as a listener sees the low line and asks its power stage to shut down. The channels can sit on several devices, because the only link between them is the open-drain line.

Each channel has its own response mode. In retry mode the source lets go of the line once a programmable number of 10 µs ticks has passed with its fault gone, and only while its fault-cleared input is high. In latch-off mode it keeps the line low until its enable falls and rises again. The enable is the run input ANDed with the on/off command. When the line returns high, every enabled, fault-free channel gets a one-cycle soft-start trigger in the same clock. A global clear-all option lets a run rising edge on any channel clear the fault state of every channel.

Top module: `fault_group_ctrl`

## Requirements
- R1: A channel with source enable set and enable (run AND on/off command) high that sees its fault request high drives its pull-down output high one clock later.
- R2: A listening channel raises its shutdown output three clocks after the shared line input goes low (two synchronizer flops, then the output register) and not earlier. A channel holding its own fault also keeps shutdown high.
- R3: In retry mode (mode input 0) the pull-down falls only after the fault request has stayed low for `retry_ticks` ticks of `TICK_DIV` clocks each, and only while fault-cleared is high. A fault request during the count restarts it.
- R4: When the synchronized shared line rises, every channel that is enabled and fault-free pulses soft-start for exactly one clock, all in the same cycle. The pulse comes three clocks after the line rises, and shutdown is low during it.
- R5: In latch-off mode (mode input 1) the pull-down stays high whatever the fault request and fault-cleared do, including while the enable is low, until the enable rises.
- R6: A rising edge of a channel's enable clears that channel's fault state in either mode, so its pull-down is low one clock later.
- R7: With `clr_all_cfg` high, a rising edge of any channel's run input clears every channel's fault state. With it low, a run edge on another channel leaves a held fault unchanged.
- R8: A fault request on a channel with source enable low leaves its pull-down low.
- R9: A channel with listen enable low keeps shutdown low while the line is driven low from outside. A low line never records a fault, so a channel cannot hold itself off through its own pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_line_in | input | 1 | Sampled level of the shared active-low fault line |
| ch_fault_req | input | NUM_CH | Internal fault request per channel |
| ch_fault_clr | input | NUM_CH | Fault condition has cleared, per channel |
| ch_run | input | NUM_CH | Run input per channel |
| ch_on_cmd | input | NUM_CH | On/off command per channel, 1 = on |
| ch_latch_mode | input | NUM_CH | Response mode, 1 = latch-off, 0 = retry |
| ch_src_en | input | NUM_CH | Channel may pull the shared line |
| ch_listen_en | input | NUM_CH | Channel shuts down on a low shared line |
| retry_ticks | input | RETRY_W | Retry interval in ticks |
| clr_all_cfg | input | 1 | A run edge on any channel clears all channels |
| fault_pull | output | NUM_CH | Open-drain pull-down enable per channel |
| ch_shutdown | output | NUM_CH | Shutdown request per channel |
| ch_softstart | output | NUM_CH | One-cycle soft-start trigger per channel |

## Verification
The bench closes the wired-AND loop, so the source's pull-down drives the line that the listeners see. It measures the retry release window with the tick rate scaled down. A count that ignored reasserted faults would release early in the restart case, and an off-by-one in the synchronizer would move shutdown and soft-start away from the third clock. Latched faults are held through long idle periods, through an off phase, and through run toggles on a neighbour with clear-all off. A design that released on fault-cleared, on enable falling, or on any channel's run edge would drop the pull-down too soon. A scoreboard expects exactly one group soft-start mask per release, so missing, duplicate or staggered triggers all show up.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;
  typedef enum logic [1:0] {
    CH_OK    = 2'd0,
    CH_RETRY = 2'd1,
    CH_LATCH = 2'd2
  } ch_state_e;
endpackage

// File: rtl/fgc_tick.sv
`timescale 1ns/1ps
// Divides the clock down to the retry time base (one pulse per TICK_DIV clocks).
module fgc_tick #(
  parameter int TICK_DIV = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick    <= (div_cnt == LAST);
      div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fgc_line_sync.sv
`timescale 1ns/1ps
// Brings the shared line into the clock domain and flags its rising edge.
module fgc_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_low,
  output logic line_rise
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[SYNC_STAGES-1:0], line_in};
  end

  assign line_low  = ~shreg[SYNC_STAGES-1];
  assign line_rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/fgc_chan.sv
`timescale 1ns/1ps
// Per-channel fault state: records own faults, times retry, holds latch-off.
module fgc_chan
  import fgc_pkg::*;
#(
  parameter int RETRY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               fault_req,
  input  logic               fault_clr,
  input  logic               run,
  input  logic               on_cmd,
  input  logic               src_en,
  input  logic               listen_en,
  input  logic               latch_mode,
  input  logic [RETRY_W-1:0] retry_ticks,
  input  logic               group_clr,
  input  logic               line_low,
  input  logic               line_rise,
  output logic               run_rise,
  output logic               pull,
  output logic               shutdown,
  output logic               softstart
);
  logic active, active_q, run_q, own_clr;
  ch_state_e st, st_n;
  logic [RETRY_W-1:0] cnt, cnt_n;

  assign active   = run & on_cmd;
  assign own_clr  = active & ~active_q;
  assign run_rise = run & ~run_q;

  // Only the channel's own request records a fault; a low line never does.
  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (own_clr | group_clr) begin
      st_n  = CH_OK;
      cnt_n = '0;
    end else begin
      case (st)
        CH_OK: begin
          if (fault_req & src_en & active) begin
            st_n  = latch_mode ? CH_LATCH : CH_RETRY;
            cnt_n = '0;
          end
        end
        CH_RETRY: begin
          if (fault_req)                 cnt_n = '0;
          else if (cnt >= retry_ticks) begin
            if (fault_clr)               st_n  = CH_OK;
          end else if (tick)             cnt_n = cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CH_OK;
      cnt       <= '0;
      active_q  <= 1'b0;
      run_q     <= 1'b0;
      pull      <= 1'b0;
      shutdown  <= 1'b0;
      softstart <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      active_q  <= active;
      run_q     <= run;
      pull      <= (st_n != CH_OK);
      shutdown  <= (st_n != CH_OK) | (listen_en & line_low);
      softstart <= line_rise & active & (st_n == CH_OK);
    end
  end
endmodule

// File: rtl/fault_group_ctrl.sv
`timescale 1ns/1ps
module fault_group_ctrl #(
  parameter int NUM_CH   = 2,
  parameter int RETRY_W  = 16,
  parameter int TICK_DIV = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fault_line_in,
  input  logic [NUM_CH-1:0]  ch_fault_req,
  input  logic [NUM_CH-1:0]  ch_fault_clr,
  input  logic [NUM_CH-1:0]  ch_run,
  input  logic [NUM_CH-1:0]  ch_on_cmd,
  input  logic [NUM_CH-1:0]  ch_latch_mode,
  input  logic [NUM_CH-1:0]  ch_src_en,
  input  logic [NUM_CH-1:0]  ch_listen_en,
  input  logic [RETRY_W-1:0] retry_ticks,
  input  logic               clr_all_cfg,
  output logic [NUM_CH-1:0]  fault_pull,
  output logic [NUM_CH-1:0]  ch_shutdown,
  output logic [NUM_CH-1:0]  ch_softstart
);
  logic tick, line_low, line_rise, group_clr;
  logic [NUM_CH-1:0] run_rise;

  fgc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  fgc_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .line_in(fault_line_in),
    .line_low(line_low), .line_rise(line_rise)
  );

  assign group_clr = clr_all_cfg & (|run_rise);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fgc_chan #(.RETRY_W(RETRY_W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick),
      .fault_req(ch_fault_req[g]), .fault_clr(ch_fault_clr[g]),
      .run(ch_run[g]), .on_cmd(ch_on_cmd[g]),
      .src_en(ch_src_en[g]), .listen_en(ch_listen_en[g]),
      .latch_mode(ch_latch_mode[g]), .retry_ticks(retry_ticks),
      .group_clr(group_clr), .line_low(line_low), .line_rise(line_rise),
      .run_rise(run_rise[g]), .pull(fault_pull[g]),
      .shutdown(ch_shutdown[g]), .softstart(ch_softstart[g])
    );
  end
endmodule

// File: rtl/fgc_checker.sv
`timescale 1ns/1ps
module fgc_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              fault_line_in,
  input logic [NUM_CH-1:0] ch_run,
  input logic [NUM_CH-1:0] ch_on_cmd,
  input logic [NUM_CH-1:0] ch_latch_mode,
  input logic [NUM_CH-1:0] ch_src_en,
  input logic [NUM_CH-1:0] ch_listen_en,
  input logic              clr_all_cfg,
  input logic [NUM_CH-1:0] fault_pull,
  input logic [NUM_CH-1:0] ch_shutdown,
  input logic [NUM_CH-1:0] ch_softstart
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R1 / R8: a pull-down only starts on a source-enabled channel
    p_pull_src_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(fault_pull[g]) |-> $past(ch_src_en[g]));

    // R2: line low three clocks back with listening on forces shutdown
    p_listen_shut_r2: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && !$past(fault_line_in, 3) && $past(ch_listen_en[g]))
        |-> ch_shutdown[g]);

    // R4: a soft-start pulse never overlaps shutdown
    p_ss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      ch_softstart[g] |-> !ch_shutdown[g] && !fault_pull[g]);

    // R5: a latched pull-down only falls on enable high or clear-all
    p_latch_release_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(fault_pull[g]) && $past(ch_latch_mode[g]))
        |-> ($past(ch_run[g] & ch_on_cmd[g]) || $past(clr_all_cfg)));
  end
endmodule

bind fault_group_ctrl fgc_checker #(.NUM_CH(NUM_CH)) u_fgc_checker (
  .clk(clk), .rst(rst), .fault_line_in(fault_line_in),
  .ch_run(ch_run), .ch_on_cmd(ch_on_cmd), .ch_latch_mode(ch_latch_mode),
  .ch_src_en(ch_src_en), .ch_listen_en(ch_listen_en),
  .clr_all_cfg(clr_all_cfg), .fault_pull(fault_pull),
  .ch_shutdown(ch_shutdown), .ch_softstart(ch_softstart)
);

// File: tb/test_fault_group_ctrl.sv
`timescale 1ns/1ps
module test_fault_group_ctrl;
  localparam int NUM_CH = 2;
  localparam int RETRY_W = 8;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_n = 1'b1;
  logic [NUM_CH-1:0] fault_req = '0, fault_clr = '1, run = '1, on_cmd = '1;
  logic [NUM_CH-1:0] latch = '0, src = 2'b01, listen = '1;
  logic [RETRY_W-1:0] retry_ticks = 8'd3;
  logic clr_all = 1'b0;
  logic [NUM_CH-1:0] pull, shut, ss;
  logic line;

  int nchk = 0, nbad = 0;
  bit finished = 0;
  logic [1:0] ss_q[$];

  assign line = ext_n & ~(|pull);

  always #2.5 clk = ~clk;

  fault_group_ctrl #(.NUM_CH(NUM_CH), .RETRY_W(RETRY_W), .TICK_DIV(TICK_DIV)) i_fault_group_ctrl (
    .clk(clk), .rst(rst), .fault_line_in(line),
    .ch_fault_req(fault_req), .ch_fault_clr(fault_clr), .ch_run(run),
    .ch_on_cmd(on_cmd), .ch_latch_mode(latch), .ch_src_en(src),
    .ch_listen_en(listen), .retry_ticks(retry_ticks), .clr_all_cfg(clr_all),
    .fault_pull(pull), .ch_shutdown(shut), .ch_softstart(ss)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ss(input logic [1:0] m);
    ss_q.push_back(m);
  endtask

  task automatic fault0();
    fault_req[0] = 1'b1;
    cyc(1);
    fault_req[0] = 1'b0;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (pull[0] && n < 300) begin
      cyc(1);
      n++;
    end
  endtask

  // scoreboard monitor for soft-start masks
  always @(negedge clk) begin
    if (!rst && ss != '0) begin
      nchk++;
      if (ss_q.size() == 0) begin
        nbad++;
        $display("FAIL R4 unexpected softstart actual=%0d expected=none", ss);
      end else begin
        logic [1:0] e;
        e = ss_q.pop_front();
        if (ss != e) begin
          nbad++;
          $display("FAIL R4 softstart mask actual=%0d expected=%0d", ss, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    rst = 1'b0;
    cyc(2);
    check("reset pull", pull, 0);
    check("reset shutdown", shut, 0);
    check("reset softstart", ss, 0);

    // R1, R2, R3 retry path
    fault_req[0] = 1'b1;
    cyc(1);
    fault_req[0] = 1'b0;
    check("R1 pull on fault", pull[0], 1);
    check("R2 faulted channel shutdown", shut[0], 1);
    expect_ss(2'b11);
    cyc(1); check("R2 no shutdown at clock 1", shut[1], 0);
    cyc(1); check("R2 no shutdown at clock 2", shut[1], 0);
    cyc(1); check("R2 listener shutdown at clock 3", shut[1], 1);
    wait_release(n);
    n += 3;
    check("R3 retry release not early", int'(n >= 9), 1);
    check("R3 retry release not late", int'(n <= 14), 1);
    cyc(6);
    check("R4 shutdown cleared after rise", shut, 0);

    // R3 restart on reassert
    fault0();
    cyc(5);
    fault0();
    wait_release(n);
    check("R3 count restarts", int'(n >= 9 && n <= 14), 1);
    expect_ss(2'b11);
    cyc(6);

    // R3 hold while fault not cleared
    fault_clr[0] = 1'b0;
    fault0();
    cyc(30);
    check("R3 hold while not cleared", pull[0], 1);
    fault_clr[0] = 1'b1;
    expect_ss(2'b11);
    wait_release(n);
    check("R3 release once cleared", int'(n <= 2), 1);
    cyc(6);

    // R5 latch-off
    latch[0] = 1'b1;
    fault0();
    cyc(40);
    check("R5 latched hold", pull[0], 1);
    on_cmd[0] = 1'b0;
    cyc(3);
    check("R5 held while off", pull[0], 1);
    on_cmd[0] = 1'b1;
    expect_ss(2'b11);
    cyc(1);
    check("R5 R6 on command clears", pull[0], 0);
    cyc(6);

    // R6 run toggle clears latched and retry faults
    fault0();
    run[0] = 1'b0;
    cyc(2);
    check("R6 held while run low", pull[0], 1);
    run[0] = 1'b1;
    expect_ss(2'b11);
    cyc(1);
    check("R6 run toggle clears latch", pull[0], 0);
    cyc(6);
    latch[0] = 1'b0;
    retry_ticks = 8'd200;
    fault0();
    cyc(10);
    run[0] = 1'b0;
    cyc(2);
    run[0] = 1'b1;
    expect_ss(2'b11);
    cyc(1);
    check("R6 run toggle clears retry", pull[0], 0);
    cyc(6);
    retry_ticks = 8'd3;
    latch[0] = 1'b1;

    // R7 global clear
    fault0();
    run[1] = 1'b0;
    cyc(2);
    run[1] = 1'b1;
    cyc(3);
    check("R7 neighbour run edge ignored", pull[0], 1);
    clr_all = 1'b1;
    run[1] = 1'b0;
    cyc(2);
    run[1] = 1'b1;
    expect_ss(2'b11);
    cyc(1);
    check("R7 clear-all via neighbour", pull[0], 0);
    clr_all = 1'b0;
    cyc(6);

    // R8 source disabled
    fault_req[1] = 1'b1;
    cyc(3);
    check("R8 no pull without source enable", pull, 0);
    fault_req[1] = 1'b0;
    cyc(2);

    // R9 listen disabled, external low
    listen[1] = 1'b0;
    ext_n = 1'b0;
    cyc(4);
    check("R9 non-listener stays up", shut[1], 0);
    check("R2 listener down on external low", shut[0], 1);
    check("R9 low line records no fault", pull, 0);
    ext_n = 1'b1;
    expect_ss(2'b11);
    cyc(6);
    check("R9 listener recovers", shut[0], 0);
    listen[1] = 1'b1;

    cyc(4);
    check("R4 all soft-starts seen", ss_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule